// File: doc/BRIEF.md
# Exception Entry Sequencer

This block sits beside a small CPU core and decides when the core must leave straight-line execution to handle a reset, an interrupt or a trap. Once it decides, it takes over a word-wide memory port and a few register write strobes, and it runs the entry sequence. For interrupts and traps it saves the return address and the condition bits on the stack. For every kind of entry it reads a start address from the vector table and loads it into the program counter. While the sequence runs it holds the core stalled.

The core reports instruction boundaries with an end strobe and an inhibit flag. The inhibit flag is raised for the few instructions that rewrite the condition register directly. The core also pulses a strobe when it executes a trap instruction. The interrupt controller presents a single request with its vector number. Priority is fixed: reset first, then interrupt, then trap. An interrupt is sampled only at a boundary, either the end of an instruction or the last cycle of an entry sequence. The boundary that closes a reset entry is never used for an interrupt, and neither is the end of an instruction that rewrites the condition bits. A trap is taken as soon as its strobe fires while the core is running.

Top module: `exc_entry_seq`

## Requirements
- R1: After `rst_n` rises, the first cycle following the next clock edge issues a read at address 0 with no write. In the cycle after that, `pc_we` and `done` are high and `pc_new` equals the low `PC_W` bits of `mem_rdata`. A reset entry never writes memory, `sp_we` or `ccr_we`.
- R2: While `rst_n` is low, `busy` is high and `mem_req`, `sp_we`, `pc_we` and `ccr_we` are low. Pulling `rst_n` low in the middle of an entry sequence abandons that sequence. A fresh reset entry follows once `rst_n` rises again.
- R3: When the block is idle and `insn_end` is high, it accepts an interrupt if `irq_req` is high, `insn_inhibit` is low and bit MASK_BIT (default 7) of `ccr_cur` is clear. The first push appears in the next cycle and `exc_kind` reads 2. If the mask bit is set, the request is not taken.
- R4: An interrupt request that arrives at an instruction end with `insn_inhibit` high is not taken at that boundary.
- R5: The `done` cycle that closes a reset entry never starts an interrupt entry, even when a request is present and unmasked.
- R6: A `trap_exec` pulse while the block is idle always starts a trap entry (`exc_kind` = 3). This holds whatever the state of the mask bit, `insn_inhibit` or `insn_end`.
- R7: If an interrupt is accepted in the same cycle as a trap strobe, the interrupt entry runs first. The trap entry then starts straight from that sequence's `done` cycle, and it saves the interrupt handler address and the masked condition bits.
- R8: The entry sequence writes twice. The first write goes to SP-4 and carries the return PC, zero-extended to 32 bits. The second write goes to SP-8 and carries {CCR[7:0], PC zero-extended to 24 bits}. In the cycle of the second write, `sp_we` is high and `sp_new` equals SP-8.
- R9: The cycle after the last push reads address vector*4. The cycle after that read loads the PC from the read data.
- R10: In the load cycle of an interrupt entry, `ccr_we` is high and `ccr_new` equals the saved CCR with bit MASK_BIT set. A trap entry writes no CCR when TRAP_MASKS = 0.
- R11: In the `done` cycle of an interrupt or trap entry, an unmasked request starts a new interrupt entry in the next cycle with no idle gap. That entry pushes the address that was just loaded.
- R12: `busy` stays high from the first cycle of a sequence through its `done` cycle, and `done` lasts one cycle. While `busy` is high and `done` is low, `trap_exec` and `irq_req` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset pin; its rising edge starts reset entry |
| insn_end | input | 1 | Core finished an instruction this cycle |
| insn_inhibit | input | 1 | The finishing instruction rewrote the condition bits |
| irq_req | input | 1 | Interrupt request from the controller |
| irq_vec | input | VEC_W (6) | Vector number of the request |
| trap_exec | input | 1 | Core executed a trap instruction |
| trap_vec | input | VEC_W (6) | Vector number of the trap |
| pc_cur | input | PC_W (24) | Return address presented by the core |
| ccr_cur | input | 8 | Current condition bits |
| sp_cur | input | ADDR_W (24) | Current stack pointer |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W (24) | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| sp_we | output | 1 | Stack pointer write strobe |
| sp_new | output | ADDR_W (24) | New stack pointer |
| pc_we | output | 1 | Program counter load strobe |
| pc_new | output | PC_W (24) | New program counter |
| ccr_we | output | 1 | Condition register write strobe |
| ccr_new | output | 8 | New condition bits |
| busy | output | 1 | Core must stall |
| done | output | 1 | Last cycle of an entry sequence |
| exc_kind | output | 2 | Entry in progress: 1 reset, 2 interrupt, 3 trap |

## Verification
Random boundaries mix the instruction-end strobe, the inhibit flag, the mask bit, the request and the trap strobe. This shows whether each gate alone blocks an interrupt while leaving traps untouched. Boundaries that carry both a request and a trap separate correct ordering from either event being lost. A request held across a trap entry separates chained entry at the `done` boundary from entry deferred to the next instruction. It also checks that the freshly set mask stops a second take. Directed reset cases cover release with a live unmasked request, which separates the reset blackout from an ordinary boundary, and reset asserted midway through a push.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;
   localparam int WORD_W = 32;
   localparam int CCR_W  = 8;
   localparam int PCX_W  = WORD_W - CCR_W;

   typedef enum logic [1:0] {
      K_NONE  = 2'd0,
      K_RESET = 2'd1,
      K_IRQ   = 2'd2,
      K_TRAP  = 2'd3
   } exc_kind_t;

   typedef enum logic [2:0] {
      S_RST   = 3'd0,
      S_IDLE  = 3'd1,
      S_PUSH1 = 3'd2,
      S_PUSH2 = 3'd3,
      S_VEC   = 3'd4,
      S_LOAD  = 3'd5
   } exc_state_t;
endpackage

// File: rtl/exc_arbiter.sv
`timescale 1ns/1ps
// Boundary decision: which entry, if any, starts at the next edge.
module exc_arbiter (
   input  logic in_idle,
   input  logic in_done,
   input  logic done_is_reset,
   input  logic insn_end,
   input  logic insn_inhibit,
   input  logic irq_req,
   input  logic mask_eff,
   input  logic trap_exec,
   input  logic trap_pend,
   output logic take_irq,
   output logic take_trap,
   output logic set_pend,
   output logic clr_pend
);
   logic irq_window;
   logic trap_ready;

   always_comb begin
      // instruction boundary, unless it rewrote the condition bits
      irq_window = (in_idle && insn_end && !insn_inhibit) ||
                   (in_done && !done_is_reset);
      take_irq   = irq_window && irq_req && !mask_eff;
      trap_ready = (in_idle && trap_exec) || (in_done && trap_pend);
      take_trap  = trap_ready && !take_irq;
      set_pend   = trap_ready && take_irq;
      clr_pend   = take_trap;
   end
endmodule

// File: rtl/exc_ctrl.sv
`timescale 1ns/1ps
// Sequence state and the values captured at entry.
module exc_ctrl #(
   parameter int PC_W   = 24,
   parameter int ADDR_W = 24,
   parameter int VEC_W  = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     take_irq,
   input  logic                     take_trap,
   input  logic                     set_pend,
   input  logic                     clr_pend,
   input  logic                     trap_exec,
   input  logic [VEC_W-1:0]         irq_vec,
   input  logic [VEC_W-1:0]         trap_vec,
   input  logic [PC_W-1:0]          pc_src,
   input  logic [exc_pkg::CCR_W-1:0] ccr_src,
   input  logic [ADDR_W-1:0]        sp_cur,
   output exc_pkg::exc_state_t      state_o,
   output exc_pkg::exc_kind_t       kind_o,
   output logic [VEC_W-1:0]         vec_o,
   output logic [PC_W-1:0]          pc_o,
   output logic [exc_pkg::CCR_W-1:0] ccr_o,
   output logic [ADDR_W-1:0]        sp_o,
   output logic                     pend_o
);
   import exc_pkg::*;

   localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(4);

   exc_state_t state;
   exc_kind_t  kind;
   logic [VEC_W-1:0]  vec_q;
   logic [VEC_W-1:0]  tvec_q;
   logic [PC_W-1:0]   pc_q;
   logic [CCR_W-1:0]  ccr_q;
   logic [ADDR_W-1:0] sp_q;
   logic              pend_q;
   logic [VEC_W-1:0]  trap_pick;

   // a trap taken straight from idle uses the live vector, a deferred one the held copy
   assign trap_pick = (state == S_IDLE) ? trap_vec : tvec_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= S_RST;
         kind   <= K_RESET;
         vec_q  <= '0;
         tvec_q <= '0;
         pc_q   <= '0;
         ccr_q  <= '0;
         sp_q   <= '0;
         pend_q <= 1'b0;
      end else begin
         case (state)
            S_RST:   state <= S_VEC;
            S_PUSH1: begin
               state <= S_PUSH2;
               sp_q  <= sp_q - SLOT;
            end
            S_PUSH2: state <= S_VEC;
            S_VEC:   state <= S_LOAD;
            default: state <= S_IDLE;
         endcase
         if (take_irq) begin
            state <= S_PUSH1;
            kind  <= K_IRQ;
            vec_q <= irq_vec;
            pc_q  <= pc_src;
            ccr_q <= ccr_src;
            sp_q  <= sp_cur - SLOT;
         end else if (take_trap) begin
            state <= S_PUSH1;
            kind  <= K_TRAP;
            vec_q <= trap_pick;
            pc_q  <= pc_src;
            ccr_q <= ccr_src;
            sp_q  <= sp_cur - SLOT;
         end
         if (state == S_IDLE && trap_exec) tvec_q <= trap_vec;
         if (set_pend)      pend_q <= 1'b1;
         else if (clr_pend) pend_q <= 1'b0;
      end
   end

   // R7: a held trap only exists while an interrupt entry runs
   assert_pend_only_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && state != S_IDLE) |-> (kind == K_IRQ));

   assign state_o = state;
   assign kind_o  = kind;
   assign vec_o   = vec_q;
   assign pc_o    = pc_q;
   assign ccr_o   = ccr_q;
   assign sp_o    = sp_q;
   assign pend_o  = pend_q;
endmodule

// File: rtl/exc_port.sv
`timescale 1ns/1ps
// Drives the memory port and register strobes from the sequence state.
module exc_port #(
   parameter int PC_W     = 24,
   parameter int ADDR_W   = 24,
   parameter int VEC_W    = 6,
   parameter int MASK_BIT = 7
) (
   input  exc_pkg::exc_state_t        state,
   input  logic                       loads_mask,
   input  logic [VEC_W-1:0]           vec_q,
   input  logic [PC_W-1:0]            pc_q,
   input  logic [exc_pkg::CCR_W-1:0]  ccr_q,
   input  logic [ADDR_W-1:0]          sp_q,
   input  logic [exc_pkg::WORD_W-1:0] mem_rdata,
   output logic                       mem_req,
   output logic                       mem_we,
   output logic [ADDR_W-1:0]          mem_addr,
   output logic [exc_pkg::WORD_W-1:0] mem_wdata,
   output logic                       sp_we,
   output logic [ADDR_W-1:0]          sp_new,
   output logic                       pc_we,
   output logic [PC_W-1:0]            pc_new,
   output logic                       ccr_we,
   output logic [exc_pkg::CCR_W-1:0]  ccr_new,
   output logic                       busy,
   output logic                       done
);
   import exc_pkg::*;

   localparam logic [CCR_W-1:0] MASK_ONE = CCR_W'(1) << MASK_BIT;

   logic [PCX_W-1:0]  pc_ext;
   logic [ADDR_W-1:0] vec_addr;
   logic              unused_rdata_hi;

   assign pc_ext          = PCX_W'(pc_q);
   assign vec_addr        = ADDR_W'({vec_q, 2'b00});
   assign unused_rdata_hi = ^mem_rdata[WORD_W-1:PC_W];

   always_comb begin
      mem_req   = (state == S_PUSH1) || (state == S_PUSH2) || (state == S_VEC);
      mem_we    = (state == S_PUSH1) || (state == S_PUSH2);
      mem_addr  = (state == S_VEC) ? vec_addr : sp_q;
      mem_wdata = (state == S_PUSH1) ? WORD_W'(pc_q) : {ccr_q, pc_ext};
      sp_we     = (state == S_PUSH2);
      sp_new    = sp_q;
      pc_we     = (state == S_LOAD);
      pc_new    = mem_rdata[PC_W-1:0];
      ccr_we    = (state == S_LOAD) && loads_mask;
      ccr_new   = ccr_q | MASK_ONE;
      busy      = (state != S_IDLE);
      done      = (state == S_LOAD);
   end
endmodule

// File: rtl/exc_entry_seq.sv
`timescale 1ns/1ps
module exc_entry_seq #(
   parameter int PC_W       = 24,
   parameter int ADDR_W     = 24,
   parameter int VEC_W      = 6,
   parameter int MASK_BIT   = 7,
   parameter int TRAP_MASKS = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              insn_end,
   input  logic              insn_inhibit,
   input  logic              irq_req,
   input  logic [VEC_W-1:0]  irq_vec,
   input  logic              trap_exec,
   input  logic [VEC_W-1:0]  trap_vec,
   input  logic [PC_W-1:0]   pc_cur,
   input  logic [7:0]        ccr_cur,
   input  logic [ADDR_W-1:0] sp_cur,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   output logic              sp_we,
   output logic [ADDR_W-1:0] sp_new,
   output logic              pc_we,
   output logic [PC_W-1:0]   pc_new,
   output logic              ccr_we,
   output logic [7:0]        ccr_new,
   output logic              busy,
   output logic              done,
   output logic [1:0]        exc_kind
);
   import exc_pkg::*;

   if (PC_W < 2 || PC_W > PCX_W) begin : g_bad_pc
      $error("PC_W must lie in 2..%0d", PCX_W);
   end
   if (ADDR_W < VEC_W + 2) begin : g_bad_addr
      $error("ADDR_W too narrow for the vector table");
   end
   if (MASK_BIT < 0 || MASK_BIT >= CCR_W) begin : g_bad_mask
      $error("MASK_BIT outside the condition register");
   end
   if (TRAP_MASKS != 0 && TRAP_MASKS != 1) begin : g_bad_trap
      $error("TRAP_MASKS must be 0 or 1");
   end

   exc_state_t        state;
   exc_kind_t         kind;
   logic [VEC_W-1:0]  vec_q;
   logic [PC_W-1:0]   pc_q;
   logic [CCR_W-1:0]  ccr_q;
   logic [ADDR_W-1:0] sp_q;
   logic              trap_pend;
   logic              loads_mask;
   logic              in_idle, in_done, mask_eff;
   logic [CCR_W-1:0]  ccr_load;
   logic [PC_W-1:0]   pc_src;
   logic [CCR_W-1:0]  ccr_src;
   logic              take_irq, take_trap, set_pend, clr_pend;

   if (TRAP_MASKS != 0) begin : g_trap_masks
      assign loads_mask = (kind == K_IRQ) || (kind == K_TRAP);
   end else begin : g_trap_keeps
      assign loads_mask = (kind == K_IRQ);
   end

   assign in_idle  = (state == S_IDLE);
   assign in_done  = (state == S_LOAD);
   // on a done boundary the bits being loaded are the ones that count
   assign ccr_load = loads_mask ? ccr_new : ccr_cur;
   assign mask_eff = in_done ? ccr_load[MASK_BIT] : ccr_cur[MASK_BIT];
   assign pc_src   = in_done ? mem_rdata[PC_W-1:0] : pc_cur;
   assign ccr_src  = in_done ? ccr_load : ccr_cur;
   assign exc_kind = kind;

   exc_arbiter u_arb (
      .in_idle      (in_idle),
      .in_done      (in_done),
      .done_is_reset(kind == K_RESET),
      .insn_end     (insn_end),
      .insn_inhibit (insn_inhibit),
      .irq_req      (irq_req),
      .mask_eff     (mask_eff),
      .trap_exec    (trap_exec),
      .trap_pend    (trap_pend),
      .take_irq     (take_irq),
      .take_trap    (take_trap),
      .set_pend     (set_pend),
      .clr_pend     (clr_pend)
   );

   exc_ctrl #(.PC_W(PC_W), .ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .take_irq (take_irq),
      .take_trap(take_trap),
      .set_pend (set_pend),
      .clr_pend (clr_pend),
      .trap_exec(trap_exec),
      .irq_vec  (irq_vec),
      .trap_vec (trap_vec),
      .pc_src   (pc_src),
      .ccr_src  (ccr_src),
      .sp_cur   (sp_cur),
      .state_o  (state),
      .kind_o   (kind),
      .vec_o    (vec_q),
      .pc_o     (pc_q),
      .ccr_o    (ccr_q),
      .sp_o     (sp_q),
      .pend_o   (trap_pend)
   );

   exc_port #(.PC_W(PC_W), .ADDR_W(ADDR_W), .VEC_W(VEC_W), .MASK_BIT(MASK_BIT)) u_port (
      .state     (state),
      .loads_mask(loads_mask),
      .vec_q     (vec_q),
      .pc_q      (pc_q),
      .ccr_q     (ccr_q),
      .sp_q      (sp_q),
      .mem_rdata (mem_rdata),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .sp_we     (sp_we),
      .sp_new    (sp_new),
      .pc_we     (pc_we),
      .pc_new    (pc_new),
      .ccr_we    (ccr_we),
      .ccr_new   (ccr_new),
      .busy      (busy),
      .done      (done)
   );

   assert_inhibit_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_idle && insn_end && insn_inhibit && !trap_exec && !trap_pend) |=> !busy);

   assert_no_irq_after_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && exc_kind == 2'd1) |=> !busy);

   assert_trap_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_idle && trap_exec) |=> (busy && mem_we));

   assert_push_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && !sp_we) |=> (mem_we && sp_we && mem_addr == $past(mem_addr) - ADDR_W'(4)));

   assert_vec_then_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |=> (pc_we && done));

   assert_mask_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ccr_we |-> ccr_new[MASK_BIT]);

   assert_busy_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: tb/exc_entry_seq_tb.sv
`timescale 1ns/1ps
module exc_entry_seq_tb;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        insn_end = 1'b0, insn_inhibit = 1'b0, irq_req = 1'b0, trap_exec = 1'b0;
   logic [5:0]  irq_vec = '0, trap_vec = '0;
   logic [23:0] pc_cur = 24'h002000;
   logic [7:0]  ccr_cur = 8'h80;
   logic [23:0] sp_cur = 24'h000400;
   logic        mem_req, mem_we, sp_we, pc_we, ccr_we, busy, done;
   logic [23:0] mem_addr, sp_new, pc_new;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic [7:0]  ccr_new;
   logic [1:0]  exc_kind;
   logic        ccr_wr_b = 1'b0;
   logic [7:0]  ccr_val_b = '0;

   int n_chk = 0;
   int n_bad = 0;

   exc_entry_seq u_dut (
      .clk(clk), .rst_n(rst_n), .insn_end(insn_end), .insn_inhibit(insn_inhibit),
      .irq_req(irq_req), .irq_vec(irq_vec), .trap_exec(trap_exec), .trap_vec(trap_vec),
      .pc_cur(pc_cur), .ccr_cur(ccr_cur), .sp_cur(sp_cur),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .sp_we(sp_we), .sp_new(sp_new), .pc_we(pc_we), .pc_new(pc_new),
      .ccr_we(ccr_we), .ccr_new(ccr_new), .busy(busy), .done(done), .exc_kind(exc_kind)
   );

   function automatic logic [23:0] handler(input logic [5:0] v);
      return 24'h001000 + {14'd0, v, 4'd0};
   endfunction

   // core and memory model: vector table computed, one-cycle read latency
   always @(posedge clk) begin
      if (mem_req && !mem_we) mem_rdata <= 32'(handler(mem_addr[7:2]));
      if (pc_we) pc_cur <= pc_new;
      else if (insn_end && !busy) pc_cur <= pc_cur + 24'd2;
      if (ccr_we) ccr_cur <= ccr_new;
      else if (ccr_wr_b) ccr_cur <= ccr_val_b;
      if (sp_we) sp_cur <= sp_new;
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic set_ccr(input logic [7:0] v);
      @(negedge clk);
      ccr_wr_b = 1'b1; ccr_val_b = v;
      @(negedge clk);
      ccr_wr_b = 1'b0;
   endtask

   // called at the negedge of the first push cycle; returns at the negedge of the load cycle
   task automatic seq_check(input bit is_irq, input logic [5:0] v, input logic [23:0] pc0,
                            input logic [7:0] ccr0, input logic [23:0] sp0, input bit poke);
      chk("R12", "busy in push", busy, 1);
      chk(is_irq ? "R3" : "R6", "kind", exc_kind, is_irq ? 2 : 3);
      chk("R8", "push1 req/we", {mem_req, mem_we}, 2'b11);
      chk("R8", "push1 addr", mem_addr, sp0 - 24'd4);
      chk("R8", "push1 data", mem_wdata, {8'h00, pc0});
      if (poke) begin
         trap_exec = 1'b1; trap_vec = 6'h3f; irq_vec = 6'h3e;
      end
      @(negedge clk);
      trap_exec = 1'b0;
      chk("R8", "push2 addr", mem_addr, sp0 - 24'd8);
      chk("R8", "push2 data", mem_wdata, {ccr0, pc0});
      chk("R8", "sp write", {sp_we, sp_new}, {1'b1, sp0 - 24'd8});
      @(negedge clk);
      chk("R9", "vector read", {mem_req, mem_we, mem_addr}, {2'b10, 16'd0, v, 2'b00});
      @(negedge clk);
      chk("R9", "pc load", {pc_we, pc_new}, {1'b1, handler(v)});
      chk("R12", "done", done, 1);
      chk("R10", "ccr write", ccr_we, is_irq);
      if (is_irq) chk("R10", "ccr value", ccr_new, ccr0 | 8'h80);
   endtask

   task automatic step(input bit e, input bit inh, input bit irq, input logic [5:0] iv,
                       input bit trp, input logic [5:0] tv);
      logic [23:0] pc0, sp0;
      logic [7:0]  ccr0;
      bit irq_ok;
      @(negedge clk);
      pc0 = pc_cur; ccr0 = ccr_cur; sp0 = sp_cur;
      insn_end = e; insn_inhibit = inh; irq_req = irq; irq_vec = iv;
      trap_exec = trp; trap_vec = tv;
      irq_ok = e && irq && !inh && !ccr0[7];
      @(negedge clk);
      insn_end = 1'b0; insn_inhibit = 1'b0; irq_req = 1'b0; trap_exec = 1'b0;
      if (irq_ok) begin
         seq_check(1'b1, iv, pc0, ccr0, sp0, 1'b0);
         if (trp) begin
            @(negedge clk);
            seq_check(1'b0, tv, handler(iv), ccr0 | 8'h80, sp0 - 24'd8, 1'b0);   // R7
         end
         @(negedge clk);
         chk("R12", "idle after entry", busy, 0);
      end else if (trp) begin
         seq_check(1'b0, tv, pc0, ccr0, sp0, 1'b0);
         @(negedge clk);
         chk("R6", "idle after trap", busy, 0);
      end else begin
         chk((inh && e && irq) ? "R4" : "R3", "not taken", busy, 0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [23:0] pc0, sp0;
      logic [7:0]  ccr0;
      void'($urandom(32'd1234));
      // R2 / R5: reset held with a live, unmasked request
      irq_req = 1'b1; irq_vec = 6'd3;
      set_ccr(8'h00);
      @(negedge clk);
      chk("R2", "busy in reset", busy, 1);
      chk("R2", "strobes in reset", {mem_req, sp_we, pc_we, ccr_we}, 4'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "reset vector read", {mem_req, mem_we, mem_addr}, {2'b10, 24'd0});
      chk("R1", "reset kind", exc_kind, 1);
      @(negedge clk);
      chk("R1", "reset pc load", {pc_we, pc_new, done}, {1'b1, handler(6'd0), 1'b1});
      chk("R1", "reset no ccr/sp", {ccr_we, sp_we}, 2'b00);
      @(negedge clk);
      chk("R5", "no irq after reset", busy, 0);
      irq_req = 1'b0;

      // directed boundaries
      set_ccr(8'h00); step(1, 0, 1, 6'd5, 0, 6'd0);    // R3 taken
      set_ccr(8'h80); step(1, 0, 1, 6'd5, 0, 6'd0);    // R3 masked
      set_ccr(8'h00); step(1, 1, 1, 6'd7, 0, 6'd0);    // R4 inhibit
      set_ccr(8'h80); step(1, 1, 1, 6'd2, 1, 6'd9);    // R6 trap through both gates
      set_ccr(8'h00); step(1, 0, 1, 6'd4, 1, 6'd10);   // R7 same boundary
      set_ccr(8'h00); step(0, 0, 0, 6'd0, 1, 6'd11);   // R6 without insn_end

      // R11: request raised during a trap entry chains at its done boundary
      set_ccr(8'h05);
      @(negedge clk);
      pc0 = pc_cur; ccr0 = ccr_cur; sp0 = sp_cur;
      trap_exec = 1'b1; trap_vec = 6'd12;
      @(negedge clk);
      trap_exec = 1'b0; irq_req = 1'b1; irq_vec = 6'd20;
      seq_check(1'b0, 6'd12, pc0, ccr0, sp0, 1'b1);     // R12 trap strobe mid-sequence ignored
      irq_vec = 6'd20;
      @(negedge clk);
      chk("R11", "chained kind", exc_kind, 2);
      seq_check(1'b1, 6'd20, handler(6'd12), ccr0, sp0 - 24'd8, 1'b0);
      @(negedge clk);
      chk("R11", "mask stops retake", busy, 0);
      irq_req = 1'b0;

      // R2: reset in the middle of a push
      set_ccr(8'h00);
      @(negedge clk);
      insn_end = 1'b1; irq_req = 1'b1; irq_vec = 6'd8;
      @(negedge clk);
      insn_end = 1'b0; irq_req = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R2", "abort busy", busy, 1);
      chk("R2", "abort strobes", {mem_req, sp_we, pc_we, ccr_we}, 4'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2", "re-entry vector read", {mem_req, mem_we, mem_addr}, {2'b10, 24'd0});
      @(negedge clk);
      chk("R1", "re-entry pc load", {pc_we, pc_new}, {1'b1, handler(6'd0)});
      @(negedge clk);
      chk("R1", "idle after reset", busy, 0);

      // constrained random boundaries
      for (int i = 0; i < 150; i++) begin
         logic [7:0] cv;
         cv = {($urandom % 2) == 0, 7'($urandom)};
         set_ccr(cv);
         step(($urandom % 4) != 0, ($urandom % 4) == 0, ($urandom % 2) == 0, 6'($urandom),
              ($urandom % 4) == 0, 6'($urandom));
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule